// File: doc/BRIEF.md
# Dual-Range Auto-Ranging Monitor Channel

This block post-processes one analog monitor channel whose converter can run in two calibrated ranges. The fine range has a higher gain, and its result is divided down by a programmable right-shift. The coarse range covers the full input swing and is never shifted. A timeslice starts when the channel scheduler hands a token over the `slice` valid/ready pair. The block then requests a fine conversion from the external converter port and shifts the returned code right by 0 to 7 bits.

The block then chooses between reporting that fine value and requesting a second, coarse conversion. It makes the choice with hysteresis, based on the range that the previous timeslice reported. Coarse results are floored at a minimum that depends on the shift count. The block presents the chosen value on a result valid/ready pair. A status bit shows which range produced the latest result. Two static controls let software pin the channel to fine-only or coarse-only operation.

Back-pressure rules:
- A slice token is taken only while `slice_ready` is high, which is only when no timeslice is in progress.
- A converter request is held, with a fixed range bit, until `cv_req_ready` is seen.
- A converter response is taken in the cycle `cv_rsp_valid` is high while a response is awaited.
- A result stays valid and unchanged until `res_ready` is seen.

Top module: `range_select_mon`

## Requirements
- R1: After reset, `range_flag` is 0, `res_valid` and `cv_req_valid` are 0, and `slice_ready` is 1.
- R2: The first converter request of every timeslice is a fine request (`cv_req_coarse` = 0), in every mode.
- R3: A reported fine result equals the fine converter code shifted right by the shift count n (0 to 7) that was latched for the timeslice.
- R4: In auto mode (both force bits 0), when the previous result was fine, a coarse request follows if and only if the shifted fine value is at least 0xF000 >> n.
- R5: In auto mode, when the previous result was coarse, a coarse request follows if and only if the shifted fine value is at least 0xFFF8 >> n. Otherwise the fine value is reported and `range_flag` returns to 0.
- R6: A reported coarse result is the unshifted coarse code, raised to 0xF000 >> n when it is below that value. `range_flag` is then 1.
- R7: With force-fine 1 and force-coarse 0, every timeslice reports the fine value, even at full scale. No coarse request is made and `range_flag` is 0.
- R8: With force-coarse 1, every timeslice reports a coarse result, regardless of the fine value or force-fine.
- R9: `res_valid` with `res_data` stays stable until `res_ready`, and `slice_ready` stays low from acceptance until the result is taken. A pending converter request holds its range bit until accepted.
- R10: The shift count and the force bits are sampled when the slice token is accepted. Changes to them during the timeslice have no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slice_valid | input | 1 | Timeslice token offered |
| slice_ready | output | 1 | Token accepted (block idle) |
| cfg_shift | input | 3 | Fine-range right-shift count n |
| cfg_force_fine | input | 1 | Force fine-only reporting |
| cfg_force_coarse | input | 1 | Force coarse reporting (wins over force-fine) |
| cv_req_valid | output | 1 | Conversion request |
| cv_req_ready | input | 1 | Converter accepts the request |
| cv_req_coarse | output | 1 | Requested range: 0 fine, 1 coarse |
| cv_rsp_valid | input | 1 | Conversion code valid |
| cv_rsp_data | input | 16 | Raw conversion code |
| res_valid | output | 1 | Reported result valid |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 16 | Reported 16-bit value |
| range_flag | output | 1 | Range of the latest result: 0 fine, 1 coarse |

## Verification
When a slice token is accepted at a clock edge, the fine request is visible in the next cycle. When the request is accepted, the response can be driven in the following cycle. The coarse request, or the result with its updated `range_flag`, appears in the cycle after the response edge. The result clears in the cycle after `res_ready` is seen.

The bench drives every input on the falling edge and samples on the next falling edge, exactly one register stage after the edge that consumed the stimulus. It keeps its own record of the previous range, so the hysteresis decisions and the clamped coarse values are predicted independently of the design.

// File: rtl/rsm_pkg.sv
package rsm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FREQ,
    ST_FWAIT,
    ST_CREQ,
    ST_CWAIT,
    ST_OUT
  } rsm_state_e;
endpackage

// File: rtl/rsm_thresh.sv
// Shift-dependent range thresholds, built as a table over all shift counts.
module rsm_thresh #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic [SW-1:0] shift,
  output logic [DW-1:0] fine_max,
  output logic [DW-1:0] coarse_min
);
  localparam int NSH = 1 << SW;
  localparam logic [DW-1:0] FMAX_BASE = {DW{1'b1}} << 3;
  localparam logic [DW-1:0] CMIN_BASE = {DW{1'b1}} << (DW - 4);

  logic [DW-1:0] fmax_tab [NSH];
  logic [DW-1:0] cmin_tab [NSH];

  for (genvar i = 0; i < NSH; i++) begin : g_tab
    assign fmax_tab[i] = FMAX_BASE >> i;
    assign cmin_tab[i] = CMIN_BASE >> i;
  end

  assign fine_max   = fmax_tab[shift];
  assign coarse_min = cmin_tab[shift];
endmodule

// File: rtl/rsm_datapath.sv
// Fine-range scaling and coarse-range floor.
module rsm_datapath #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic [DW-1:0] raw,
  input  logic [SW-1:0] shift,
  input  logic [DW-1:0] coarse_min,
  output logic [DW-1:0] fine_val,
  output logic [DW-1:0] coarse_val
);
  assign fine_val   = raw >> shift;
  assign coarse_val = (raw < coarse_min) ? coarse_min : raw;
endmodule

// File: rtl/rsm_decide.sv
// Range choice with hysteresis on the previous timeslice's range.
module rsm_decide #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] fine_val,
  input  logic [DW-1:0] fine_max,
  input  logic [DW-1:0] coarse_min,
  input  logic          prev_coarse,
  input  logic          force_fine,
  input  logic          force_coarse,
  output logic          want_coarse
);
  always_comb begin
    if (force_coarse)     want_coarse = 1'b1;
    else if (force_fine)  want_coarse = 1'b0;
    else if (prev_coarse) want_coarse = (fine_val >= fine_max);
    else                  want_coarse = (fine_val >= coarse_min);
  end
endmodule

// File: rtl/rsm_seq.sv
// Timeslice sequencer: fine request, optional coarse request, result hold.
module rsm_seq #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slice_valid,
  output logic          slice_ready,
  input  logic [SW-1:0] cfg_shift,
  input  logic          cfg_force_fine,
  input  logic          cfg_force_coarse,
  output logic [SW-1:0] shift_q,
  output logic          force_fine_q,
  output logic          force_coarse_q,
  output logic          cv_req_valid,
  input  logic          cv_req_ready,
  output logic          cv_req_coarse,
  input  logic          cv_rsp_valid,
  input  logic [DW-1:0] fine_val,
  input  logic [DW-1:0] coarse_val,
  input  logic          want_coarse,
  output logic          flag_q,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data
);
  import rsm_pkg::*;

  rsm_state_e    st;
  logic [DW-1:0] res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st             <= ST_IDLE;
      shift_q        <= '0;
      force_fine_q   <= 1'b0;
      force_coarse_q <= 1'b0;
      flag_q         <= 1'b0;
      res_q          <= '0;
    end else begin
      case (st)
        ST_IDLE: if (slice_valid) begin
          shift_q        <= cfg_shift;
          force_fine_q   <= cfg_force_fine;
          force_coarse_q <= cfg_force_coarse;
          st             <= ST_FREQ;
        end
        ST_FREQ: if (cv_req_ready) st <= ST_FWAIT;
        ST_FWAIT: if (cv_rsp_valid) begin
          if (want_coarse) begin
            st <= ST_CREQ;
          end else begin
            res_q  <= fine_val;
            flag_q <= 1'b0;
            st     <= ST_OUT;
          end
        end
        ST_CREQ: if (cv_req_ready) st <= ST_CWAIT;
        ST_CWAIT: if (cv_rsp_valid) begin
          res_q  <= coarse_val;
          flag_q <= 1'b1;
          st     <= ST_OUT;
        end
        ST_OUT: if (res_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign slice_ready   = (st == ST_IDLE);
  assign cv_req_valid  = (st == ST_FREQ) || (st == ST_CREQ);
  assign cv_req_coarse = (st == ST_CREQ);
  assign res_valid     = (st == ST_OUT);
  assign res_data      = res_q;
endmodule

// File: rtl/range_select_mon.sv
module range_select_mon #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slice_valid,
  output logic          slice_ready,
  input  logic [SW-1:0] cfg_shift,
  input  logic          cfg_force_fine,
  input  logic          cfg_force_coarse,
  output logic          cv_req_valid,
  input  logic          cv_req_ready,
  output logic          cv_req_coarse,
  input  logic          cv_rsp_valid,
  input  logic [DW-1:0] cv_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          range_flag
);
  logic [SW-1:0] shift_q;
  logic          ff_q, fc_q, flag_q, want_coarse;
  logic [DW-1:0] fine_max, coarse_min, fine_val, coarse_val;

  rsm_thresh #(.DW(DW), .SW(SW)) u_thresh (
    .shift(shift_q), .fine_max(fine_max), .coarse_min(coarse_min)
  );

  rsm_datapath #(.DW(DW), .SW(SW)) u_dp (
    .raw(cv_rsp_data), .shift(shift_q), .coarse_min(coarse_min),
    .fine_val(fine_val), .coarse_val(coarse_val)
  );

  rsm_decide #(.DW(DW)) u_decide (
    .fine_val(fine_val), .fine_max(fine_max), .coarse_min(coarse_min),
    .prev_coarse(flag_q), .force_fine(ff_q), .force_coarse(fc_q),
    .want_coarse(want_coarse)
  );

  rsm_seq #(.DW(DW), .SW(SW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .slice_valid(slice_valid), .slice_ready(slice_ready),
    .cfg_shift(cfg_shift), .cfg_force_fine(cfg_force_fine),
    .cfg_force_coarse(cfg_force_coarse),
    .shift_q(shift_q), .force_fine_q(ff_q), .force_coarse_q(fc_q),
    .cv_req_valid(cv_req_valid), .cv_req_ready(cv_req_ready),
    .cv_req_coarse(cv_req_coarse), .cv_rsp_valid(cv_rsp_valid),
    .fine_val(fine_val), .coarse_val(coarse_val), .want_coarse(want_coarse),
    .flag_q(flag_q), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data)
  );

  assign range_flag = flag_q;
endmodule

// File: rtl/rsm_checker.sv
module rsm_checker #(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          slice_valid,
  input logic          slice_ready,
  input logic [SW-1:0] cfg_shift,
  input logic          cv_req_valid,
  input logic          cv_req_ready,
  input logic          cv_req_coarse,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          range_flag
);
  localparam logic [DW-1:0] FLOOR_BASE = {4'hF, {(DW-4){1'b0}}};
  localparam logic [DW-1:0] ONES = {DW{1'b1}};

  logic [SW-1:0] sh_seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_seen <= '0;
    else if (slice_valid && slice_ready) sh_seen <= cfg_shift;
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (!res_valid && !cv_req_valid && !range_flag && slice_ready));

  a_r2_first_req_fine: assert property (@(posedge clk) disable iff (!rst_n)
    (slice_valid && slice_ready) |=> (cv_req_valid && !cv_req_coarse));

  a_r3_fine_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !range_flag) |-> (res_data <= (ONES >> sh_seen)));

  a_r6_coarse_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && range_flag) |-> (res_data >= (FLOOR_BASE >> sh_seen)));

  a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(range_flag)));

  a_r9_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cv_req_valid && !cv_req_ready) |=> (cv_req_valid && $stable(cv_req_coarse)));

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid || cv_req_valid) |-> !slice_ready);
endmodule

bind range_select_mon rsm_checker #(.DW(DW), .SW(SW)) u_rsm_chk (
  .clk(clk), .rst_n(rst_n), .slice_valid(slice_valid), .slice_ready(slice_ready),
  .cfg_shift(cfg_shift), .cv_req_valid(cv_req_valid), .cv_req_ready(cv_req_ready),
  .cv_req_coarse(cv_req_coarse), .res_valid(res_valid), .res_ready(res_ready),
  .res_data(res_data), .range_flag(range_flag)
);

// File: tb/test_range_select_mon.sv
module test_range_select_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slice_valid = 1'b0;
  logic        slice_ready;
  logic [2:0]  cfg_shift = '0;
  logic        cfg_force_fine = 1'b0;
  logic        cfg_force_coarse = 1'b0;
  logic        cv_req_valid;
  logic        cv_req_ready = 1'b0;
  logic        cv_req_coarse;
  logic        cv_rsp_valid = 1'b0;
  logic [15:0] cv_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [15:0] res_data;
  logic        range_flag;

  int n_checks = 0;
  int n_errors = 0;
  logic prev_c = 1'b0;

  always #10 clk = ~clk;

  range_select_mon i_range_select_mon (
    .clk(clk), .rst_n(rst_n), .slice_valid(slice_valid), .slice_ready(slice_ready),
    .cfg_shift(cfg_shift), .cfg_force_fine(cfg_force_fine),
    .cfg_force_coarse(cfg_force_coarse), .cv_req_valid(cv_req_valid),
    .cv_req_ready(cv_req_ready), .cv_req_coarse(cv_req_coarse),
    .cv_rsp_valid(cv_rsp_valid), .cv_rsp_data(cv_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .range_flag(range_flag)
  );

  function automatic logic [15:0] fmax(input logic [2:0] n);
    return 16'hFFF8 >> n;
  endfunction
  function automatic logic [15:0] cmin(input logic [2:0] n);
    return 16'hF000 >> n;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_req(input string req);
    for (int i = 0; i < 8 && !cv_req_valid; i++) @(negedge clk);
    chk(cv_req_valid, req, {31'd0, cv_req_valid}, 1);
  endtask

  // One timeslice: fine conversion, optional coarse, result handshake.
  task automatic do_slice(input logic [2:0] n, input logic ff, input logic fc,
                          input logic [15:0] fraw, input logic [15:0] craw,
                          input int stall, input logic chg, input string req);
    logic [15:0] sv, ed;
    logic wc;
    sv = fraw >> n;
    if (fc)          wc = 1'b1;
    else if (ff)     wc = 1'b0;
    else if (prev_c) wc = (sv >= fmax(n));
    else             wc = (sv >= cmin(n));
    ed = wc ? ((craw < cmin(n)) ? cmin(n) : craw) : sv;

    cfg_shift = n; cfg_force_fine = ff; cfg_force_coarse = fc;
    slice_valid = 1'b1;
    @(negedge clk);
    slice_valid = 1'b0;
    if (chg) begin  // R10: config moves after acceptance
      cfg_shift = ~n; cfg_force_fine = ~ff; cfg_force_coarse = ~fc;
    end
    wait_req(req);
    chk(!cv_req_coarse, "R2 first request fine", {31'd0, cv_req_coarse}, 0);
    cv_req_ready = 1'b1; @(negedge clk); cv_req_ready = 1'b0;
    cv_rsp_valid = 1'b1; cv_rsp_data = fraw; @(negedge clk); cv_rsp_valid = 1'b0;
    if (wc) begin
      chk(cv_req_valid && cv_req_coarse, {req, " coarse request"},
          {30'd0, cv_req_valid, cv_req_coarse}, 3);
      cv_req_ready = 1'b1; @(negedge clk); cv_req_ready = 1'b0;
      cv_rsp_valid = 1'b1; cv_rsp_data = craw; @(negedge clk); cv_rsp_valid = 1'b0;
    end else begin
      chk(!cv_req_valid, {req, " no coarse request"}, {31'd0, cv_req_valid}, 0);
    end
    chk(res_valid && res_data == ed, {req, " result"}, {15'd0, res_valid, res_data},
        {15'd1, ed});
    chk(range_flag == wc, {req, " range flag"}, {31'd0, range_flag}, {31'd0, wc});
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk(res_valid && res_data == ed && !slice_ready, "R9 hold under back-pressure",
          {14'd0, res_valid, slice_ready, res_data}, {15'd1, 1'b0, ed});
    end
    res_ready = 1'b1; @(negedge clk); res_ready = 1'b0;
    chk(!res_valid && slice_ready, "R9 release after res_ready",
        {30'd0, res_valid, slice_ready}, 1);
    prev_c = wc;
  endtask

  task automatic t_reset;
    chk(!res_valid && !cv_req_valid && !range_flag && slice_ready, "R1 reset state",
        {28'd0, res_valid, cv_req_valid, range_flag, slice_ready}, 1);
  endtask

  task automatic t_fine_shifts;
    for (int n = 0; n < 8; n++) do_slice(3'(n), 0, 0, 16'h1234, 16'h0, 0, 0, "R3");
  endtask

  task automatic t_enter_coarse;
    do_slice(3'd2, 0, 0, 16'hEFFC, 16'h0, 0, 0, "R4 below entry");
    do_slice(3'd2, 0, 0, 16'hF000, 16'h8000, 0, 0, "R4 at entry");
  endtask

  task automatic t_hysteresis;
    do_slice(3'd2, 0, 0, 16'hFFF4, 16'h0, 0, 0, "R5 below fine max");
    do_slice(3'd2, 0, 0, 16'hFFF8, 16'h9000, 0, 0, "R4 re-enter");
    do_slice(3'd2, 0, 0, 16'hF000, 16'h0, 0, 0, "R5 entry level leaves coarse");
    do_slice(3'd2, 0, 0, 16'hFFFC, 16'h9100, 0, 0, "R4 re-enter");
    do_slice(3'd2, 0, 0, 16'hFFF8, 16'hA000, 0, 0, "R5 at fine max stays coarse");
  endtask

  task automatic t_clamp;
    do_slice(3'd4, 0, 0, 16'hFFFF, 16'h0100, 0, 0, "R6 floor");
    do_slice(3'd4, 0, 0, 16'hFFF0, 16'h2000, 0, 0, "R6 above floor");
  endtask

  task automatic t_force_fine;
    do_slice(3'd0, 1, 0, 16'hFFFF, 16'h0, 0, 0, "R7");
    do_slice(3'd0, 1, 0, 16'hFFFF, 16'h0, 0, 0, "R7");
  endtask

  task automatic t_force_coarse;
    do_slice(3'd0, 0, 1, 16'h0000, 16'h0005, 0, 0, "R8");
    do_slice(3'd3, 1, 1, 16'h0010, 16'h3000, 0, 0, "R8 both set");
  endtask

  task automatic t_backpressure;
    do_slice(3'd0, 1, 0, 16'h0400, 16'h0, 4, 0, "R9");
  endtask

  task automatic t_cfg_latch;
    do_slice(3'd1, 0, 0, 16'h1000, 16'h0, 0, 1, "R10");
  endtask

  initial begin
    #(20 * 100000);
    n_errors++;
    $display("FAIL R9 watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fine_shifts();
    t_enter_coarse();
    t_hysteresis();
    t_clamp();
    t_force_fine();
    t_force_coarse();
    t_backpressure();
    t_cfg_latch();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end
endmodule